// File: doc/BRIEF.md
# NAND Flash Host Port with Single-Error-Correcting Parity

This block sits between a simple register bus and a byte-wide NAND flash device. Software drives the device through three kinds of register: a data port, whose bytes go out on the NAND I/O lines or come back from them; a control register, whose low bits drive the two chip selects, the command-latch and address-latch strobes and the write-protect pin, and whose bit 5 shows the device's ready/busy line; and a group of parity registers.

Every byte that crosses the data port, whether it is written or read, is folded into a Hamming-style parity code over a 256-byte chunk. The code has a 16-bit line parity and a 6-bit column parity. A byte counter shows how far into the chunk the transfer has gone. Software clears the accumulators before a chunk, moves the data, and then reads the parity. The block only produces the code. Comparing codes and correcting a flipped bit is left to software.

Top module: `nand_host_ecc`

## Requirements
- R1: While reset is asserted and right after it: nand_ce0_n=1, nand_ce1_n=1, nand_cle=0, nand_ale=0, nand_wp_n=0, nand_we_n=1, nand_re_n=1 and nand_io_oe=0. Line parity, column parity and the byte counter are zero.
- R2: A write to the control register at offset 0x18 sets the pins from the write data: bit0 to nand_ce0_n, bit1 to nand_cle, bit2 to nand_ale, bit3 to nand_wp_n, bit4 to nand_ce1_n. The pins change at the edge that accepts the request. Write bits 7..5 have no effect. A read returns bits 4..0 as last written, bit 5 as the ready/busy status, and zeros in bits 7..6.
- R3: Bit 5 of a control-register read is the level of nand_rb (1 = ready) seen through a two-flop synchronizer. A register read accepted in the cycle right after nand_rb changes still returns the old level. A read accepted one cycle later returns the new level.
- R4: A write to the data port at offset 0x14 puts the data on nand_io_out with nand_io_oe=1 and nand_we_n=0 for exactly one cycle. This starts at the edge that accepts the request.
- R5: A read of the data port drives nand_re_n low for one cycle, starting at the accepting edge. The next edge captures nand_io_in, and the captured byte is returned with bus_rvalid two cycles after the request. A request made while nand_re_n is low is ignored.
- R6: A read of any register other than the data port returns its value with bus_rvalid one cycle after the request.
- R7: Line parity is 16 bits, with bits 7..0 at offset 0x00 and bits 15..8 at offset 0x04. For byte index i within the chunk and k in 0..7, bit 2k+1 is the XOR of the XOR-reduced bytes whose index has bit k set. Bit 2k covers the bytes whose index has bit k clear.
- R8: Column parity is read at offset 0x08 with bits 7..6 zero. For g in 0..2, bit 2g+1 is the XOR of every data bit j in the chunk where bit g of j is set. Bit 2g covers the data bits where bit g of j is clear.
- R9: The byte counter is read at offset 0x0C. It advances by one for every data-port byte and returns to 0 after 256 bytes.
- R10: A write of any value to offset 0x10 clears line parity, column parity and the byte counter.
- R11: Data-port reads and data-port writes update the parity and the counter in the same way.
- R12: Writes to unmapped offsets (such as 0x1C) change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 8 | Read data |
| nand_io_out | output | 8 | Data driven toward the flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Data from the flash |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce0_n | output | 1 | Chip select 0, active low |
| nand_ce1_n | output | 1 | Chip select 1, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp_n | output | 1 | Write-protect pin level |
| nand_rb | input | 1 | Ready/busy from the flash, 1 = ready |

## Verification
The parity engine is tried with several data patterns. A single 0x01 byte at index 0 sets only the even halves of every parity pair, so a swapped pair shows up. A short burst of writes and a short burst of reads run over the same model and show that both directions update the code. A full 256-byte chunk that mixes reads and writes with varied data covers every index bit and the return of the counter to zero. Clears are issued with zero and with nonzero data. Control writes with opposite bit patterns, an unmapped access and a ready/busy change read just before and just after the synchronizer settles check the pin mapping and the status delay.

// File: rtl/nhe_pkg.sv
package nhe_pkg;
    localparam int DATA_W      = 8;
    localparam int CHUNK_BYTES = 256;
    localparam int ADDR_W      = 5;
    localparam int IDX_W       = $clog2(CHUNK_BYTES);
    localparam int LP_W        = 2 * IDX_W;
    localparam int COL_SEL_W   = $clog2(DATA_W);
    localparam int CP_W        = 2 * COL_SEL_W;
    localparam int RB_STAGES   = 2;

    localparam logic [ADDR_W-1:0] OFS_LP_LO = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_LP_HI = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CP    = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_CTL   = 5'h18;

    typedef enum logic [2:0] {
        SEL_LP_LO, SEL_LP_HI, SEL_CP, SEL_CNT,
        SEL_CLR, SEL_DATA, SEL_CTL, SEL_NONE
    } reg_sel_e;

    // control register image, bit 4 down to bit 0
    typedef struct packed {
        logic ce1_n;
        logic wp_n;
        logic ale;
        logic cle;
        logic ce0_n;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{ce1_n: 1'b1, wp_n: 1'b0, ale: 1'b0,
                                   cle: 1'b0, ce0_n: 1'b1};

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_LP_LO: return SEL_LP_LO;
            OFS_LP_HI: return SEL_LP_HI;
            OFS_CP:    return SEL_CP;
            OFS_CNT:   return SEL_CNT;
            OFS_CLR:   return SEL_CLR;
            OFS_DATA:  return SEL_DATA;
            OFS_CTL:   return SEL_CTL;
            default:   return SEL_NONE;
        endcase
    endfunction

    // mask of data bit positions whose index bit g equals hi
    function automatic logic [DATA_W-1:0] col_mask(input int g, input logic hi);
        logic [DATA_W-1:0] m;
        for (int j = 0; j < DATA_W; j++) begin
            m[j] = (((j >> g) & 1) == (hi ? 1 : 0));
        end
        return m;
    endfunction
endpackage

// File: rtl/nhe_rb_sync.sv
module nhe_rb_sync #(
    parameter int STAGES = nhe_pkg::RB_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/nhe_ecc_acc.sv
module nhe_ecc_acc
    import nhe_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int I_W = IDX_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        upd,
    input  logic [D_W-1:0]              din,
    output logic [2*I_W-1:0]            lp,
    output logic [2*$clog2(D_W)-1:0]    cp,
    output logic [I_W-1:0]              cnt
);
    localparam int L_W   = 2 * I_W;
    localparam int SEL_W = $clog2(D_W);
    localparam int C_W   = 2 * SEL_W;

    logic           byte_par;
    logic [L_W-1:0] lp_flip;
    logic [C_W-1:0] cp_flip;

    assign byte_par = ^din;

    // line parity: the byte's parity lands in the half selected by each index bit
    for (genvar k = 0; k < I_W; k++) begin : g_line
        assign lp_flip[2*k]   = byte_par & ~cnt[k];
        assign lp_flip[2*k+1] = byte_par &  cnt[k];
    end

    // column parity: each bit-index bit splits the data bits into two halves
    for (genvar g = 0; g < SEL_W; g++) begin : g_col
        localparam logic [D_W-1:0] MASK_LO = col_mask(g, 1'b0);
        localparam logic [D_W-1:0] MASK_HI = col_mask(g, 1'b1);
        assign cp_flip[2*g]   = ^(din & MASK_LO);
        assign cp_flip[2*g+1] = ^(din & MASK_HI);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lp  <= '0;
            cp  <= '0;
            cnt <= '0;
        end else if (upd) begin
            lp  <= lp ^ lp_flip;
            cp  <= cp ^ cp_flip;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nhe_strobe.sv
module nhe_strobe
    import nhe_pkg::*;
#(
    parameter int D_W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_go,
    input  logic           rd_go,
    input  logic [D_W-1:0] wdata,
    input  logic [D_W-1:0] io_in,
    output logic [D_W-1:0] io_out,
    output logic           io_oe,
    output logic           we_n,
    output logic           re_n,
    output logic           cap_valid,
    output logic [D_W-1:0] cap_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            io_out    <= '0;
            io_oe     <= 1'b0;
            we_n      <= 1'b1;
            re_n      <= 1'b1;
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            we_n      <= ~wr_go;
            io_oe     <= wr_go;
            re_n      <= ~rd_go;
            cap_valid <= ~re_n;
            if (wr_go) io_out   <= wdata;
            if (!re_n) cap_data <= io_in;
        end
    end
endmodule

// File: rtl/nand_host_ecc.sv
module nand_host_ecc
    import nhe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] nand_io_out,
    output logic              nand_io_oe,
    input  logic [DATA_W-1:0] nand_io_in,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_ce0_n,
    output logic              nand_ce1_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_wp_n,
    input  logic              nand_rb
);
    reg_sel_e          sel;
    logic              accept, wr_go, rd_go, clr_go, ctl_go, reg_rd;
    logic              rb_sync;
    logic              cap_valid;
    logic [DATA_W-1:0] cap_data;
    logic              ecc_upd;
    logic [DATA_W-1:0] ecc_din;
    logic [LP_W-1:0]   lp_acc;
    logic [CP_W-1:0]   cp_acc;
    logic [IDX_W-1:0]  cnt_acc;
    ctl_t              ctl_q;
    logic              reg_rvalid_q;
    logic [DATA_W-1:0] reg_rdata_q, reg_rdata_d;

    // a request is taken only when no read capture is in flight
    assign sel    = decode_offset(bus_addr);
    assign accept = bus_req & nand_re_n;
    assign wr_go  = accept &  bus_we & (sel == SEL_DATA);
    assign rd_go  = accept & ~bus_we & (sel == SEL_DATA);
    assign clr_go = accept &  bus_we & (sel == SEL_CLR);
    assign ctl_go = accept &  bus_we & (sel == SEL_CTL);
    assign reg_rd = accept & ~bus_we & (sel != SEL_DATA);

    nhe_rb_sync #(.STAGES(RB_STAGES)) u_rb (
        .clk      (clk),
        .rst      (rst),
        .async_in (nand_rb),
        .sync_out (rb_sync)
    );

    nhe_strobe #(.D_W(DATA_W)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .wr_go     (wr_go),
        .rd_go     (rd_go),
        .wdata     (bus_wdata),
        .io_in     (nand_io_in),
        .io_out    (nand_io_out),
        .io_oe     (nand_io_oe),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .cap_valid (cap_valid),
        .cap_data  (cap_data)
    );

    // parity sees written bytes at issue and read bytes at capture
    assign ecc_upd = wr_go | ~nand_re_n;
    assign ecc_din = wr_go ? bus_wdata : nand_io_in;

    nhe_ecc_acc #(.D_W(DATA_W), .I_W(IDX_W)) u_ecc (
        .clk (clk),
        .rst (rst),
        .clr (clr_go),
        .upd (ecc_upd),
        .din (ecc_din),
        .lp  (lp_acc),
        .cp  (cp_acc),
        .cnt (cnt_acc)
    );

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= CTL_RESET;
        else if (ctl_go) ctl_q <= ctl_t'(bus_wdata[$bits(ctl_t)-1:0]);
    end

    assign nand_ce0_n = ctl_q.ce0_n;
    assign nand_ce1_n = ctl_q.ce1_n;
    assign nand_cle   = ctl_q.cle;
    assign nand_ale   = ctl_q.ale;
    assign nand_wp_n  = ctl_q.wp_n;

    always_comb begin
        reg_rdata_d = '0;
        case (sel)
            SEL_LP_LO: reg_rdata_d = lp_acc[DATA_W-1:0];
            SEL_LP_HI: reg_rdata_d = DATA_W'(lp_acc >> DATA_W);
            SEL_CP:    reg_rdata_d = DATA_W'(cp_acc);
            SEL_CNT:   reg_rdata_d = DATA_W'(cnt_acc);
            SEL_CTL:   reg_rdata_d = DATA_W'({rb_sync, ctl_q});
            default:   reg_rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rvalid_q <= 1'b0;
            reg_rdata_q  <= '0;
        end else begin
            reg_rvalid_q <= reg_rd;
            if (reg_rd) reg_rdata_q <= reg_rdata_d;
        end
    end

    assign bus_rvalid = reg_rvalid_q | cap_valid;
    assign bus_rdata  = cap_valid ? cap_data : reg_rdata_q;
endmodule

// File: rtl/nhe_checker.sv
module nhe_checker
    import nhe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] nand_io_out,
    input logic              nand_we_n,
    input logic              nand_re_n,
    input logic              nand_ce0_n,
    input logic              nand_ce1_n,
    input logic              nand_cle,
    input logic              nand_ale,
    input logic              nand_wp_n,
    input logic [LP_W-1:0]   lp_acc,
    input logic [CP_W-1:0]   cp_acc,
    input logic [IDX_W-1:0]  cnt_acc
);
    logic taken;
    assign taken = bus_req && nand_re_n;

    a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |=> nand_we_n);

    a_r4_write_drive: assert property (@(posedge clk) disable iff (rst)
        (taken && bus_we && bus_addr == OFS_DATA)
        |=> (!nand_we_n && nand_io_out == $past(bus_wdata)));

    a_r5_read_capture: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |=> (nand_re_n && bus_rvalid));

    a_r6_reg_reply: assert property (@(posedge clk) disable iff (rst)
        (taken && !bus_we && bus_addr != OFS_DATA) |=> bus_rvalid);

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (taken && bus_we && bus_addr == OFS_CLR)
        |=> (cnt_acc == '0 && lp_acc == '0 && cp_acc == '0));

    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (taken && bus_we && bus_addr == OFS_DATA)
        |=> cnt_acc == $past(cnt_acc) + 1'b1);

    a_r2_pin_map: assert property (@(posedge clk) disable iff (rst)
        (taken && bus_we && bus_addr == OFS_CTL)
        |=> (nand_ce0_n == $past(bus_wdata[0]) && nand_cle == $past(bus_wdata[1])
             && nand_ale == $past(bus_wdata[2]) && nand_wp_n == $past(bus_wdata[3])
             && nand_ce1_n == $past(bus_wdata[4])));

    a_r12_unmapped_keep: assert property (@(posedge clk) disable iff (rst)
        (taken && bus_we && bus_addr == 5'h1C)
        |=> ($stable(lp_acc) && $stable(cnt_acc) && $stable(nand_ce0_n)));
endmodule

bind nand_host_ecc nhe_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rvalid  (bus_rvalid),
    .nand_io_out (nand_io_out),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_ce0_n  (nand_ce0_n),
    .nand_ce1_n  (nand_ce1_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_wp_n   (nand_wp_n),
    .lp_acc      (lp_acc),
    .cp_acc      (cp_acc),
    .cnt_acc     (cnt_acc)
);

// File: tb/nand_host_ecc_test.sv
module nand_host_ecc_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_req = 1'b0, bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rvalid;
    logic [7:0] bus_rdata, nand_io_out, nand_io_in = '0;
    logic       nand_io_oe, nand_we_n, nand_re_n, nand_ce0_n, nand_ce1_n;
    logic       nand_cle, nand_ale, nand_wp_n, nand_rb = 1'b1;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic [15:0] m_lp = '0;
    logic [5:0]  m_cp = '0;
    logic [7:0]  m_cnt = '0;

    always #4 clk = ~clk;

    nand_host_ecc uut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a read reply appears
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R6 stray reply actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic model_byte(input logic [7:0] d);
        logic p;
        p = ^d;
        for (int k = 0; k < 8; k++) begin
            if (m_cnt[k]) m_lp[2*k+1] = m_lp[2*k+1] ^ p;
            else          m_lp[2*k]   = m_lp[2*k] ^ p;
        end
        for (int j = 0; j < 8; j++) begin
            for (int g = 0; g < 3; g++) begin
                if (((j >> g) & 1) == 1) m_cp[2*g+1] = m_cp[2*g+1] ^ d[j];
                else                     m_cp[2*g]   = m_cp[2*g] ^ d[j];
            end
        end
        m_cnt = m_cnt + 8'd1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        chk({tag, " rvalid after one cycle R6"}, {7'd0, bus_rvalid}, 8'd1);
    endtask

    task automatic data_write(input logic [7:0] d, input bit pins);
        bus_write(5'h14, d);
        if (pins) begin
            chk("R4 we_n low", {7'd0, nand_we_n}, 8'd0);
            chk("R4 io_out", nand_io_out, d);
            chk("R4 io_oe", {7'd0, nand_io_oe}, 8'd1);
            @(negedge clk);
            chk("R4 we_n back high", {7'd0, nand_we_n}, 8'd1);
        end
        model_byte(d);
    endtask

    task automatic data_read(input logic [7:0] d);
        nand_io_in = d;
        exp_q.push_back(d); tag_q.push_back("R5 data read");
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 5'h14;
        @(negedge clk);
        bus_req = 1'b0;
        chk("R5 re_n low", {7'd0, nand_re_n}, 8'd0);
        @(negedge clk);
        chk("R5 re_n high", {7'd0, nand_re_n}, 8'd1);
        model_byte(d);
    endtask

    task automatic clear_ecc(input logic [7:0] d);
        bus_write(5'h10, d);
        m_lp = '0; m_cp = '0; m_cnt = '0;
    endtask

    task automatic read_ecc(input string tag);
        reg_read(5'h00, m_lp[7:0],     {tag, " R7 lp lo"});
        reg_read(5'h04, m_lp[15:8],    {tag, " R7 lp hi"});
        reg_read(5'h08, {2'b00, m_cp}, {tag, " R8 cp"});
        reg_read(5'h0C, m_cnt,         {tag, " R9 cnt"});
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 pins during reset
        chk("R1 ce0_n", {7'd0, nand_ce0_n}, 8'd1);
        chk("R1 ce1_n", {7'd0, nand_ce1_n}, 8'd1);
        chk("R1 cle/ale", {6'd0, nand_cle, nand_ale}, 8'd0);
        chk("R1 wp_n", {7'd0, nand_wp_n}, 8'd0);
        chk("R1 strobes", {5'd0, nand_we_n, nand_re_n, nand_io_oe}, 8'b110);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        read_ecc("R1 after reset");
        reg_read(5'h18, 8'h31, "R1 control reset value");

        // R2 pin mapping with two opposite patterns
        bus_write(5'h18, 8'h0A);
        chk("R2 pins 0A", {3'd0, nand_ce1_n, nand_wp_n, nand_ale, nand_cle, nand_ce0_n}, 8'h0A);
        reg_read(5'h18, 8'h2A, "R2 readback 0A");
        bus_write(5'h18, 8'hF5);
        chk("R2 pins F5", {3'd0, nand_ce1_n, nand_wp_n, nand_ale, nand_cle, nand_ce0_n}, 8'h15);
        reg_read(5'h18, 8'h35, "R2 readback F5 upper bits ignored");

        // R3 ready/busy through the synchronizer
        nand_rb = 1'b0;
        reg_read(5'h18, 8'h35, "R3 old level right after change");
        reg_read(5'h18, 8'h15, "R3 busy level");
        nand_rb = 1'b1;
        repeat (3) @(negedge clk);
        reg_read(5'h18, 8'h35, "R3 ready again");

        // R8 R7 single byte at index 0
        clear_ecc(8'h00);
        data_write(8'h01, 1'b1);
        read_ecc("single 01");
        chk("R7 model single-byte pattern", m_lp[7:0], 8'h55);

        // R10 clear with nonzero data
        clear_ecc(8'hA5);
        read_ecc("R10 clear A5");

        // R11 write burst then read burst
        data_write(8'h3C, 1'b1);
        data_write(8'hF0, 1'b1);
        data_write(8'h81, 1'b0);
        read_ecc("R11 writes");
        clear_ecc(8'h00);
        data_read(8'h3C);
        data_read(8'hF0);
        data_read(8'h81);
        read_ecc("R11 reads");

        // R5 request while re_n is low is ignored
        nand_io_in = 8'h5A;
        exp_q.push_back(8'h5A); tag_q.push_back("R5 read with blocked follower");
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 5'h14;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 5'h10; bus_wdata = 8'h00;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        model_byte(8'h5A);
        read_ecc("R5 blocked clear");

        // R9 full chunk, mixed directions, counter wraps
        clear_ecc(8'h00);
        for (int i = 0; i < 256; i++) begin
            if (i % 3 == 1) data_read(8'(i * 37 + 5));
            else            data_write(8'(i * 37 + 5), 1'b0);
        end
        read_ecc("R9 full chunk wrap");
        data_write(8'hC3, 1'b0);
        read_ecc("R9 after wrap");

        // R12 unmapped offset
        bus_write(5'h1C, 8'hFF);
        reg_read(5'h1C, 8'h00, "R12 unmapped read");
        reg_read(5'h18, 8'h35, "R12 control unchanged");
        read_ecc("R12 ecc unchanged");

        repeat (4) @(negedge clk);
        chk("R6 scoreboard drained", 8'(exp_q.size()), 8'd0);
        finish_run();
    end
endmodule